// File: doc/BRIEF.md
# GPIO Bank Interrupt Detect and Flag Unit

This unit holds the interrupt detection logic for one bank of general-purpose pins. Every pin that is in interrupt mode is watched for one of four conditions: a rising edge, a falling edge, a high level or a low level. The pin's trigger bit and direction bit choose the condition, so the direction bit acts as the interrupt polarity. A detected condition sets the pin's bit in a flag word. Software clears flag bits by writing ones through the clear path. In this bank that path is the same write port that acts as data-set for pins in plain I/O mode.

A per-pin mask decides which flags may reach the bank's single interrupt output. The same masked set is also searched for its highest-numbered pending pin. That index goes to the dispatcher, which serves the highest pin first. The bit vectors come from register storage outside this unit. The pin levels arrive already synchronized.

Two state machines do the work. Each pin has a flag machine with the states PIN_QUIET (no event latched) and PIN_PENDING (event latched):

- PIN_QUIET moves to PIN_PENDING on a detected event.
- PIN_PENDING returns to PIN_QUIET on a clear hit with no new event in the same cycle.

The bank has one output machine with the states OUT_IDLE and OUT_RAISED:

- OUT_IDLE moves to OUT_RAISED when any unmasked flag is set.
- OUT_RAISED returns to OUT_IDLE when no unmasked flag remains.

Top module: `gpio_irq_unit`

## Requirements
- R1: A pin can set its flag only while its function bit is 0 and its select bit is 1. In any other mode its flag does not get set, and entering interrupt mode does not by itself create an edge.
- R2: With trigger=1 and direction=1, a 0-to-1 change of the pin level sets the flag on the clock edge where the new level is first sampled. A 1-to-0 change does not set it.
- R3: With trigger=1 and direction=0, a 1-to-0 change sets the flag in the same way. A 0-to-1 change does not set it.
- R4: With trigger=0 and direction=1, the flag is set on every clock while the level is 1.
- R5: With trigger=0 and direction=0, the flag is set on every clock while the level is 0.
- R6: A set flag stays set until it is cleared, even after the pin returns to its idle level.
- R7: When the clear strobe is 1, each flag whose bit in the clear mask is 1 reads 0 after the next clock, and all other flags are unchanged. A level-sensitive flag whose level is still active reads 1 again after that same clock.
- R8: If a clear and a new event hit the same flag in the same cycle, the flag stays set.
- R9: A mask bit of 1 does not stop the flag from being set. It does stop that flag from driving the interrupt and from being chosen as the pending index.
- R10: The interrupt output is registered. It is 1 exactly one clock after a cycle in which the flag word ANDed with the inverted mask is non-zero, and 0 otherwise.
- R11: Pending-valid has the same timing as the interrupt. When it is 1, pending-index is the position of the most significant bit of (flags AND NOT mask) from the previous cycle. When it is 0, the index is 0.
- R12: While reset (active low, synchronous) is applied, flags, interrupt, pending-valid and index all read 0. No edge is detected on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| func_bit | input | NPINS | Per-pin function bit (0 needed for interrupt mode) |
| sel_bit | input | NPINS | Per-pin select bit (1 needed for interrupt mode) |
| dir_bit | input | NPINS | Per-pin polarity: 1 = rising/high, 0 = falling/low |
| trig_bit | input | NPINS | Per-pin sensitivity: 1 = edge, 0 = level |
| mask_bit | input | NPINS | Per-pin mask, 1 blocks the interrupt |
| clr_stb | input | 1 | Flag clear strobe |
| clr_bits | input | NPINS | Flags to clear when the strobe is 1 |
| flags | output | NPINS | Latched flag word |
| irq | output | 1 | Combined bank interrupt |
| pend_idx | output | IDXW | Highest unmasked pending pin |
| pend_vld | output | 1 | Pending index is valid |

## Verification
Suppose a pin's flag machine is left in the wrong state. Then the flag word shows the error right after the clock where the detection or clear took effect. The bank interrupt and pending index show it one clock later.

A fault in the edge history would show in several ways. Edges could be missed or phantom edges detected. A pin could be flagged when it enters interrupt mode. A flag could appear on the first clock after reset.

A fault in the priority search would show up as a wrong index whenever two or more unmasked flags are set together. The top pin of the bank is exercised on its own to catch index-width errors.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Per-pin flag machine
    typedef enum logic {
        PIN_QUIET   = 1'b0,
        PIN_PENDING = 1'b1
    } pin_state_t;

    // Bank output machine
    typedef enum logic {
        OUT_IDLE   = 1'b0,
        OUT_RAISED = 1'b1
    } out_state_t;

    // Sensitivity chosen by {trigger, direction}
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_t;

    function automatic sense_t decode_sense(input logic trig, input logic dir);
        sense_t s;
        unique case ({trig, dir})
            2'b00:   s = SENSE_LOW;
            2'b01:   s = SENSE_HIGH;
            2'b10:   s = SENSE_FALL;
            default: s = SENSE_RISE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic func,
    input  logic sel,
    input  logic dir,
    input  logic trig,
    input  logic clr_hit,
    output logic flag
);

    pin_state_t st_q, st_d;
    logic       prev_q;
    logic       armed;
    logic       hit;
    logic       evt;
    sense_t     sense;

    assign armed = ~func & sel;
    assign sense = decode_sense(trig, dir);

    // Condition detector
    always_comb begin
        unique case (sense)
            SENSE_RISE: hit = lvl & ~prev_q;
            SENSE_FALL: hit = ~lvl & prev_q;
            SENSE_HIGH: hit = lvl;
            SENSE_LOW:  hit = ~lvl;
            default:    hit = 1'b0;
        endcase
    end

    assign evt = armed & hit;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_QUIET:   if (evt) st_d = PIN_PENDING;
            PIN_PENDING: if (clr_hit && !evt) st_d = PIN_QUIET;
            default:     st_d = PIN_QUIET;
        endcase
    end

    // State register; history tracks the level in reset too
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PIN_QUIET;
            prev_q <= lvl;
        end else begin
            st_q   <= st_d;
            prev_q <= lvl;
        end
    end

    // Output process
    always_comb begin
        flag = (st_q == PIN_PENDING);
    end

    assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && (func || !sel)) |=> !flag);

    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!func && sel && trig && dir && lvl && !$past(lvl)) |=> flag);

    assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!func && sel && trig && !dir && !lvl && $past(lvl)) |=> flag);

    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_hit) |=> flag);

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hit && clr_hit) |=> flag);

endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
    parameter int NPINS = 32,
    localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [NPINS-1:0] vec,
    output logic             any,
    output logic [IDXW-1:0]  idx
);

    // Ascending scan: the last set bit seen is the highest one
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out
    import gpio_irq_pkg::*;
#(
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any,
    input  logic [IDXW-1:0] idx_in,
    output logic            irq,
    output logic            vld,
    output logic [IDXW-1:0] idx
);

    out_state_t      st_q, st_d;
    logic [IDXW-1:0] idx_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_IDLE:   if (any)  st_d = OUT_RAISED;
            OUT_RAISED: if (!any) st_d = OUT_IDLE;
            default:    st_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OUT_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= any ? idx_in : '0;
        end
    end

    always_comb begin
        irq = (st_q == OUT_RAISED);
        vld = (st_q == OUT_RAISED);
        idx = idx_q;
    end

    assert_irq_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any |=> irq);

    assert_irq_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any |=> (!irq && idx == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NPINS = 32,
    localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] func_bit,
    input  logic [NPINS-1:0] sel_bit,
    input  logic [NPINS-1:0] dir_bit,
    input  logic [NPINS-1:0] trig_bit,
    input  logic [NPINS-1:0] mask_bit,
    input  logic             clr_stb,
    input  logic [NPINS-1:0] clr_bits,
    output logic [NPINS-1:0] flags,
    output logic             irq,
    output logic [IDXW-1:0]  pend_idx,
    output logic             pend_vld
);

    logic [NPINS-1:0] flag_w;
    logic [NPINS-1:0] clr_hit;
    logic [NPINS-1:0] pend_vec;
    logic             pend_any;
    logic [IDXW-1:0]  pend_top;

    assign clr_hit  = {NPINS{clr_stb}} & clr_bits;
    assign pend_vec = flag_w & ~mask_bit;
    assign flags    = flag_w;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_irq_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (pin_lvl[g]),
            .func    (func_bit[g]),
            .sel     (sel_bit[g]),
            .dir     (dir_bit[g]),
            .trig    (trig_bit[g]),
            .clr_hit (clr_hit[g]),
            .flag    (flag_w[g])
        );
    end

    gpio_irq_prio #(.NPINS(NPINS)) u_prio (
        .vec (pend_vec),
        .any (pend_any),
        .idx (pend_top)
    );

    gpio_irq_out #(.IDXW(IDXW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .any    (pend_any),
        .idx_in (pend_top),
        .irq    (irq),
        .vld    (pend_vld),
        .idx    (pend_idx)
    );

    assert_top_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld |-> (($past(pend_vec) >> pend_idx) == NPINS'(1)));

    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && (flag_w & clr_bits) != '0 && (pin_lvl == $past(pin_lvl))
         && ((trig_bit & clr_bits) == clr_bits))
        |=> ((flag_w & $past(clr_bits)) == '0));

    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || (flags == '0 && !irq)));

endmodule

// File: tb/gpio_irq_unit_tb_top.sv
module gpio_irq_unit_tb_top;

    localparam int NPINS = 32;
    localparam int IDXW  = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NPINS-1:0] pin_lvl, func_bit, sel_bit, dir_bit, trig_bit, mask_bit, clr_bits;
    logic             clr_stb;
    logic [NPINS-1:0] flags;
    logic             irq;
    logic [IDXW-1:0]  pend_idx;
    logic             pend_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    gpio_irq_unit #(.NPINS(NPINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .func_bit(func_bit),
        .sel_bit(sel_bit), .dir_bit(dir_bit), .trig_bit(trig_bit),
        .mask_bit(mask_bit), .clr_stb(clr_stb), .clr_bits(clr_bits),
        .flags(flags), .irq(irq), .pend_idx(pend_idx), .pend_vld(pend_vld)
    );

    typedef struct packed {
        logic [7:0] lvl;
        logic [7:0] msk;
        logic       clr;
        logic [7:0] cbits;
        logic [7:0] eflg;
    } row_t;

    // Pins 0,2 rise; 1,3 fall; 4,6 level-high; 5,7 level-low
    localparam int NROWS = 18;
    localparam row_t TBL [NROWS] = '{
        '{8'hAA, 8'h00, 1'b0, 8'h00, 8'h00},  // idle
        '{8'hAB, 8'h00, 1'b0, 8'h00, 8'h01},  // R2 pin0 rises
        '{8'hAA, 8'h00, 1'b0, 8'h00, 8'h01},  // R6 sticky, R2 fall ignored
        '{8'hA8, 8'h00, 1'b0, 8'h00, 8'h03},  // R3 pin1 falls
        '{8'hAA, 8'h00, 1'b0, 8'h00, 8'h03},  // R3 rise ignored
        '{8'hAA, 8'h00, 1'b1, 8'h01, 8'h02},  // R7 clear pin0
        '{8'hBA, 8'h00, 1'b0, 8'h00, 8'h12},  // R4 pin4 high
        '{8'hBA, 8'h00, 1'b1, 8'h10, 8'h12},  // R7 level re-sets
        '{8'hAA, 8'h00, 1'b1, 8'h10, 8'h02},  // R7 clear sticks
        '{8'hAE, 8'h00, 1'b1, 8'h04, 8'h06},  // R8 event beats clear
        '{8'h8E, 8'h20, 1'b0, 8'h00, 8'h26},  // R5 pin5 low, R9 masked
        '{8'hAE, 8'h20, 1'b1, 8'h06, 8'h20},  // R7 partial clear
        '{8'hAE, 8'h20, 1'b0, 8'h00, 8'h20},  // R9 masked, no irq
        '{8'hAE, 8'h00, 1'b0, 8'h00, 8'h20},  // R10 unmask
        '{8'h2E, 8'h00, 1'b0, 8'h00, 8'hA0},  // R5 pin7 low
        '{8'hAE, 8'h00, 1'b0, 8'h00, 8'hA0},  // R11 highest is 7
        '{8'hAE, 8'h00, 1'b1, 8'hFF, 8'h00},  // R7 clear all
        '{8'hAE, 8'h00, 1'b0, 8'h00, 8'h00}   // R10 irq drops
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [IDXW-1:0] top_bit(input logic [NPINS-1:0] v);
        logic [IDXW-1:0] r = '0;
        for (int i = 0; i < NPINS; i++) if (v[i]) r = IDXW'(i);
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string req, input logic [NPINS-1:0] pend);
        check({req, " irq"}, {31'd0, irq}, {31'd0, |pend});
        check({req, " vld"}, {31'd0, pend_vld}, {31'd0, |pend});
        check({req, " idx"}, {27'd0, pend_idx}, {27'd0, top_bit(pend)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NPINS-1:0] prev_exp;
        rst_n    = 1'b0;
        pin_lvl  = 32'hAA;
        func_bit = '0;
        sel_bit  = 32'hFF;
        trig_bit = 32'h0F;
        dir_bit  = 32'h55;
        mask_bit = '0;
        clr_stb  = 1'b0;
        clr_bits = '0;
        @(negedge clk);
        tick();
        // R12 reset state
        check("R12 flags in reset", flags, '0);
        check_out("R12 reset", '0);
        rst_n = 1'b1;

        prev_exp = '0;
        for (int r = 0; r < NROWS; r++) begin
            pin_lvl  = {24'd0, TBL[r].lvl};
            mask_bit = {24'd0, TBL[r].msk};
            clr_stb  = TBL[r].clr;
            clr_bits = {24'd0, TBL[r].cbits};
            tick();
            check($sformatf("R2-row%0d flags", r), flags, {24'd0, TBL[r].eflg});
            check_out($sformatf("R10 R11 row%0d", r), prev_exp & ~mask_bit);
            prev_exp = {24'd0, TBL[r].eflg};
        end
        clr_stb = 1'b0;

        // R1: function bit set blocks a rising edge
        func_bit = 32'h1;
        pin_lvl  = 32'hAF;
        tick();
        check("R1 func set", flags, '0);
        // R1: select clear blocks it too
        func_bit = '0;
        sel_bit  = 32'hFE;
        pin_lvl  = 32'hAE;
        tick();
        pin_lvl = 32'hAF;
        tick();
        check("R1 sel clear", flags, '0);
        // R1: entering mode with level already high is no edge
        sel_bit = 32'hFF;
        tick();
        check("R1 enter mode", flags, '0);
        pin_lvl = 32'hAE;
        tick();

        // R2 at the top pin, R11 index 31
        sel_bit  = 32'h8000_00FF;
        trig_bit = 32'h8000_000F;
        dir_bit  = 32'h8000_0055;
        tick();
        check("R2 pin31 idle", flags, '0);
        pin_lvl = 32'h8000_00AE;
        tick();
        check("R2 pin31 rise", flags, 32'h8000_0000);
        check_out("R10 before", '0);
        tick();
        check_out("R11 pin31", 32'h8000_0000);
        // R9 masking removes irq one clock later, flag kept
        mask_bit = 32'h8000_0000;
        tick();
        check("R9 flag kept", flags, 32'h8000_0000);
        check_out("R9 masked", '0);
        clr_stb  = 1'b1;
        clr_bits = '1;
        tick();
        clr_stb = 1'b0;
        check("R7 clear top", flags, '0);

        // R12: reset with pin0 high, then release: no edge
        rst_n    = 1'b0;
        mask_bit = '0;
        pin_lvl  = 32'h8000_00AF;
        tick();
        check("R12 flags", flags, '0);
        check_out("R12 out", '0);
        rst_n = 1'b1;
        tick();
        check("R12 no edge after release", flags, '0);
        tick();
        check_out("R12 quiet", '0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule